// File: doc/BRIEF.md
# Pixel Word Serializer with Parity

This block takes one 27-bit pixel word per pixel clock period, adds a parity bit and two fixed framing bits, and sends the resulting 30-bit frame out over one, two or three serial lanes. All logic runs on one fast clock `clk`. The pixel clock arrives as a sampled level `pix_clk`, and a polarity input chooses which of its edges captures `pix_data`. A bit-rate enable `bit_en` advances the serial slots. The block raises a one-cycle frame strobe as the first slot of each frame leaves. Downstream this strobe stands in for the forwarded clock.

A lane-select code sets how many lanes share each frame. Lane `k` carries frame bits `k`, `k+N`, `k+2N` and so on, where `N` is the lane count, so each lane sends `30/N` slots per frame. The lane-select code is read only when a frame starts. If no word is waiting at a frame boundary, the lanes go idle and stay low.

Top module: `pixel_word_serializer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `lane_out`, `frame_strobe` and `sel_err` are all 0.
- R2: With `cap_fall`=0 a word is captured on the `clk` edge where `pix_clk` is first seen high. With `cap_fall`=1 the word is captured where `pix_clk` is first seen low. If two words are captured before a frame boundary, only the later one is sent.
- R3: Frame bit 27 is 1 when the captured word has an even number of ones, and 0 when the number is odd.
- R4: Frame bits 26..0 are the word, bit 28 is 1 and bit 29 is 0. Each lane sends its bits lowest index first.
- R5: `lane_sel` 2'b00 selects one lane, 2'b01 two lanes and 2'b10 three lanes. In slot `j`, lane `k` drives frame bit `j*N+k`. Lanes at or above `N` drive 0.
- R6: Outputs change only on `clk` edges where `bit_en` is 1. A frame lasts `30/N` enabled slots per lane.
- R7: `lane_sel` is sampled only in the slot where a new frame is loaded. A change in the middle of a frame does not affect that frame.
- R8: If a frame is loaded with `lane_sel`=2'b11, every lane stays 0, `sel_err` is 1 for that frame's 30 slots, and no strobe is given.
- R9: `frame_strobe` is 1 for exactly one `clk` cycle, namely the cycle after the `bit_en` edge that loads a valid-mode frame.
- R10: If no captured word is waiting at a frame boundary, the lanes drive 0 and `sel_err` clears on that enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_clk | input | 1 | Pixel clock level, sampled on `clk` |
| cap_fall | input | 1 | 0: capture on rising pixel edge, 1: on falling |
| pix_data | input | 27 | Parallel pixel word |
| lane_sel | input | 2 | Lane-count code |
| bit_en | input | 1 | Serial slot enable |
| lane_out | output | 3 | Serial lane outputs |
| frame_strobe | output | 1 | First-slot pulse of each frame |
| sel_err | output | 1 | Frame in flight was loaded with the unused code |

## Verification
The hardest case to reach is a lane-select change that lands in the middle of a frame. The bench must show that the change waits for the next boundary, and the frame length seen on the wire depends on which code was sampled. To get there, one phase steps `lane_sel` every seven cycles, out of phase with both the pixel edges and the frame boundaries. Another phase toggles the pixel clock faster than one-lane frames can drain, which forces the case where a newer word replaces a waiting one.

// File: rtl/pws_pkg.sv
package pws_pkg;
  localparam int unsigned SEL_W = 2;

  // Active lanes for a select code; 0 marks an unusable code.
  function automatic int unsigned lanes_of(input logic [SEL_W-1:0] code,
                                           input int unsigned max_lanes);
    int unsigned n;
    n = int'(code) + 1;
    return (n <= max_lanes) ? n : 0;
  endfunction
endpackage

// File: rtl/pix_capture.sv
module pix_capture #(
  parameter int unsigned DATA_W = 27
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_clk,
  input  logic              cap_fall,
  input  logic [DATA_W-1:0] pix_data,
  input  logic              take,
  output logic [DATA_W-1:0] word_o,
  output logic              vld_o
);
  logic pix_q;
  logic hit;

  always_comb hit = cap_fall ? (pix_q & ~pix_clk) : (~pix_q & pix_clk);

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_q  <= 1'b0;
      vld_o  <= 1'b0;
      word_o <= '0;
    end else begin
      pix_q <= pix_clk;
      if (take) vld_o <= 1'b0;
      if (hit) begin
        vld_o  <= 1'b1;
        word_o <= pix_data;
      end
    end
  end

  // R2
  capture_valid_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> vld_o);
  // R2
  capture_word_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> (word_o == $past(pix_data)));
endmodule

// File: rtl/frame_builder.sv
module frame_builder #(
  parameter int unsigned DATA_W  = 27,
  parameter int unsigned FRAME_W = DATA_W + 3
) (
  input  logic [DATA_W-1:0]  word_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic even_ones;

  always_comb begin
    even_ones = ~(^word_i);
    frame_o   = {2'b01, even_ones, word_i};
  end
endmodule

// File: rtl/lane_serializer.sv
module lane_serializer
  import pws_pkg::*;
#(
  parameter int unsigned FRAME_W = 30,
  parameter int unsigned LANES   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_en,
  input  logic [SEL_W-1:0]   lane_sel,
  input  logic [FRAME_W-1:0] new_frame,
  input  logic               new_vld,
  output logic               take_o,
  output logic [LANES-1:0]   lane_o,
  output logic               strobe_o,
  output logic               err_o
);
  localparam int unsigned CW = $clog2(FRAME_W + 1);
  localparam int unsigned IW = $clog2(FRAME_W * LANES + LANES) + 1;

  logic               busy;
  logic [CW-1:0]      cnt;
  logic [SEL_W-1:0]   mode_r;
  logic [FRAME_W-1:0] frame_r;

  logic [IW-1:0]      n_cur, n_eff, n_src, slot;
  logic               at_end;
  logic [SEL_W-1:0]   mode_src;
  logic [FRAME_W-1:0] frame_src;
  logic [LANES-1:0]   lane_nxt;

  always_comb begin
    n_cur     = IW'(lanes_of(mode_r, LANES));
    n_eff     = (n_cur == '0) ? IW'(1) : n_cur;
    at_end    = !busy || (((IW'(cnt) + IW'(1)) * n_eff) >= IW'(FRAME_W));
    mode_src  = at_end ? lane_sel : mode_r;
    frame_src = at_end ? new_frame : frame_r;
    n_src     = IW'(lanes_of(mode_src, LANES));
    slot      = at_end ? '0 : IW'(cnt) + IW'(1);
    take_o    = bit_en && at_end && new_vld;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [IW-1:0] idx;
    always_comb begin
      idx = slot * n_src + IW'(k);
      if ((n_src > IW'(k)) && (idx < IW'(FRAME_W)))
        lane_nxt[k] = frame_src[idx];
      else
        lane_nxt[k] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      mode_r   <= '0;
      frame_r  <= '0;
      lane_o   <= '0;
      strobe_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      strobe_o <= 1'b0;
      if (bit_en) begin
        if (at_end && !new_vld) begin
          busy   <= 1'b0;
          lane_o <= '0;
          err_o  <= 1'b0;
        end else begin
          lane_o <= lane_nxt;
          if (at_end) begin
            busy     <= 1'b1;
            cnt      <= '0;
            mode_r   <= lane_sel;
            frame_r  <= new_frame;
            err_o    <= (n_src == '0);
            strobe_o <= (n_src != '0);
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
      end
    end
  end

  // R8
  bad_mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (lane_o == '0));
  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    strobe_o |=> !strobe_o);
  // R9
  strobe_clean_chk: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> !err_o);
  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !(bit_en && at_end)) |=> $stable(mode_r));
  // R3
  parity_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (($countones(frame_r[FRAME_W-3:0]) % 2) == 1));
  // R6
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(lane_o));
endmodule

// File: rtl/pixel_word_serializer.sv
module pixel_word_serializer
  import pws_pkg::*;
#(
  parameter int unsigned DATA_W = 27,
  parameter int unsigned LANES  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_clk,
  input  logic              cap_fall,
  input  logic [DATA_W-1:0] pix_data,
  input  logic [SEL_W-1:0]  lane_sel,
  input  logic              bit_en,
  output logic [LANES-1:0]  lane_out,
  output logic              frame_strobe,
  output logic              sel_err
);
  localparam int unsigned FRAME_W = DATA_W + 3;

  logic [DATA_W-1:0]  word;
  logic               word_vld;
  logic               take;
  logic [FRAME_W-1:0] frame;

  pix_capture #(.DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .pix_clk  (pix_clk),
    .cap_fall (cap_fall),
    .pix_data (pix_data),
    .take     (take),
    .word_o   (word),
    .vld_o    (word_vld)
  );

  frame_builder #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_frm (
    .word_i  (word),
    .frame_o (frame)
  );

  lane_serializer #(.FRAME_W(FRAME_W), .LANES(LANES)) u_ser (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .lane_sel  (lane_sel),
    .new_frame (frame),
    .new_vld   (word_vld),
    .take_o    (take),
    .lane_o    (lane_out),
    .strobe_o  (frame_strobe),
    .err_o     (sel_err)
  );
endmodule

// File: tb/tb_pixel_word_serializer.sv
module tb_pixel_word_serializer;
  localparam int DW = 27;
  localparam int FW = 30;
  localparam int NL = 3;

  logic clk = 1'b0, rst = 1'b1, pix_clk = 1'b0, cap_fall = 1'b0, bit_en = 1'b0;
  logic [DW-1:0] pix_data = '0;
  logic [1:0]    lane_sel = 2'b00;
  logic [NL-1:0] lane_out;
  logic          frame_strobe, sel_err;

  pixel_word_serializer #(.DATA_W(DW), .LANES(NL)) dut (
    .clk(clk), .rst(rst), .pix_clk(pix_clk), .cap_fall(cap_fall),
    .pix_data(pix_data), .lane_sel(lane_sel), .bit_en(bit_en),
    .lane_out(lane_out), .frame_strobe(frame_strobe), .sel_err(sel_err)
  );

  always #5 clk = ~clk;

  int    vectors = 0, errors = 0, cyc = 0;
  bit    chk_on = 1'b0;
  string phase = "R1 reset";

  // Reference model state
  logic          pp, hv, busy;
  logic [DW-1:0] hold;
  logic [FW-1:0] frm;
  int            cnt, m;
  logic [NL-1:0] e_lane;
  logic          e_str, e_err;

  function automatic logic [FW-1:0] mk(input logic [DW-1:0] d);
    int   ones = 0;
    logic par;
    for (int i = 0; i < DW; i++) ones += int'(d[i]);
    par = ((ones % 2) == 0);   // R3 even count -> 1
    return {1'b0, 1'b1, par, d}; // R4 layout
  endfunction

  always @(posedge clk) begin : model
    int   n;
    logic eh, ae;
    if (rst) begin
      pp = 0; hv = 0; busy = 0; hold = '0; frm = '0; cnt = 0; m = 0;
      e_lane = '0; e_str = 0; e_err = 0;
    end else begin
      eh = cap_fall ? (pp && !pix_clk) : (!pp && pix_clk);
      e_str = 0;
      if (bit_en) begin
        n  = (m < NL) ? m + 1 : 1;
        ae = !busy || (cnt == FW / n - 1);
        if (ae && !hv) begin
          busy = 0; e_lane = '0; e_err = 0;
        end else begin
          if (ae) begin
            frm = mk(hold); m = int'(lane_sel); cnt = 0; busy = 1; hv = 0;
            e_err = (m >= NL); e_str = !e_err;
          end else cnt++;
          n = (m < NL) ? m + 1 : 0;
          for (int k = 0; k < NL; k++)
            e_lane[k] = (k < n) ? frm[cnt * n + k] : 1'b0;
        end
      end
      if (eh) begin hold = pix_data; hv = 1; end
      pp = pix_clk;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      vectors++;
      if (lane_out !== e_lane) begin
        errors++;
        $display("FAIL R5/R6 lane_out [%s] cyc %0d: got %b exp %b", phase, cyc, lane_out, e_lane);
      end
      if (frame_strobe !== e_str) begin
        errors++;
        $display("FAIL R9 frame_strobe [%s] cyc %0d: got %b exp %b", phase, cyc, frame_strobe, e_str);
      end
      if (sel_err !== e_err) begin
        errors++;
        $display("FAIL R8 sel_err [%s] cyc %0d: got %b exp %b", phase, cyc, sel_err, e_err);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired: got %0d cycles exp < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  function automatic logic [DW-1:0] word(input int pat);
    logic [DW-1:0] w;
    case (pat)
      1: w = '0;
      2: w = '1;
      3: for (int i = 0; i < DW; i++) w[i] = (i % 2 == 1);
      default: w = DW'($urandom);
    endcase
    return w;
  endfunction

  task automatic drive(input int cycles, input int half, input int en_div,
                       input int pat, input bit hop);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      bit_en = ((c % en_div) == 0);
      if (half > 0 && (c % half) == half - 1) begin
        pix_clk  = ~pix_clk;
        pix_data = word(pat);
      end
      if (hop && (c % 7) == 3) lane_sel = (lane_sel == 2'b10) ? 2'b00 : lane_sel + 2'b01;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    vectors++;
    if (lane_out !== '0 || frame_strobe !== 1'b0 || sel_err !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs: got %b/%b/%b exp 000/0/0", lane_out, frame_strobe, sel_err);
    end
    rst = 1'b0;
    chk_on = 1'b1;
    phase = "R1 post-reset";     drive(5, 0, 1, 0, 0);
    phase = "R2 R4 one lane";    lane_sel = 2'b00; drive(400, 20, 1, 0, 0);
    phase = "R3 zeros even";     drive(200, 20, 1, 1, 0);
    phase = "R3 ones odd";       drive(200, 20, 1, 2, 0);
    phase = "R5 two lanes";      lane_sel = 2'b01; drive(400, 20, 1, 3, 0);
    phase = "R5 R6 three lanes"; lane_sel = 2'b10; drive(400, 20, 2, 0, 0);
    phase = "R2 falling edge";   cap_fall = 1'b1; drive(400, 15, 1, 0, 0);
    phase = "R2 overwrite";      cap_fall = 1'b0; lane_sel = 2'b00; drive(400, 8, 1, 0, 0);
    phase = "R7 mid-frame hop";  drive(800, 20, 1, 0, 1);
    phase = "R8 unused code";    lane_sel = 2'b11; drive(300, 20, 1, 0, 0);
    phase = "R8 recover";        lane_sel = 2'b10; drive(200, 20, 3, 0, 0);
    phase = "R10 idle";          drive(200, 0, 1, 0, 0);
    phase = "R9 sparse enable";  lane_sel = 2'b01; drive(600, 25, 4, 0, 0);
    chk_on = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule